// File: doc/BRIEF.md
# Multiplicative Segment-ID Scrambler

This block turns a process context number and an effective address into a scrambled virtual segment identifier. It first forms a proto identifier by placing the context number above the segment-number bits taken from the address. It then multiplies the proto identifier by a fixed 24-bit prime. Finally it reduces the product modulo 2^n−1 without a divider. Because the prime and the modulus are coprime, the mapping is one-to-one, and it spreads neighbouring segments across a hashed translation table.

Two segment sizes are supported, selected per request: 256 MiB and 1 TiB. With a 68-bit virtual address, n is 40 for 256 MiB segments and 28 for 1 TiB segments. An address beyond the supported table range yields identifier 0. Identifier 0 is reserved to mean "invalid" in every case.

The work is sequenced by a three-state machine:
- `S_IDLE` waits for `start`. On `start` it takes the transition `IDLE→MUL`.
- `S_MUL` runs a shift-add multiplier that consumes `MUL_STEP` multiplier bits per cycle. It takes `MUL→MUL` until the last slice, then `MUL→FOLD`.
- `S_FOLD` performs the end-around-carry reduction, registers the result and pulses `done`. It then takes `FOLD→IDLE` unconditionally.

Top module: `vsid_scrambler`

## Requirements
- R1: The proto identifier depends on `seg_1t`.
  - With `seg_1t`=0 (256 MiB) it is {ctx, ea[48:28]}, which is 40 bits.
  - With `seg_1t`=1 (1 TiB) it is {ctx, ea[48:40]}, which is 28 bits.
  - Address bits 51:49, and the bits below the segment shift, do not affect the result.
- R2: For an in-range address, `vsid` equals (proto × 12538073) mod (2^n−1), with n=40 for `seg_1t`=0 and n=28 for `seg_1t`=1.
- R3: A produced `vsid` is always below 2^n−1. A proto equal to 2^n−1 produces 0.
- R4: An address with any of bits 63:52 set is out of range. It produces `vsid`=0 and `vsid_valid`=0.
- R5: `vsid_valid` is 1 exactly when `vsid` is nonzero. Both change only together with `done`.
- R6: `done` is a one-cycle pulse. It is high in the 7th cycle after the clock edge that accepts `start` (6 multiply cycles plus 1 reduction cycle).
- R7: `start` is ignored while a computation is in progress, including the reduction cycle. The next request is accepted at the edge after `done`. `vsid` and `vsid_valid` hold their values between `done` pulses.
- R8: After reset, the block is idle with `done`=0, `vsid`=0 and `vsid_valid`=0.
- R9: The mapping is one-to-one. Multiplying a nonzero result by 665548017062 (n=40) or 209034062 (n=28), modulo 2^n−1, recovers the proto identifier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, sampled only in S_IDLE |
| ctx | input | 19 | Context number |
| ea | input | 64 | Effective address |
| seg_1t | input | 1 | Segment size: 0 = 256 MiB, 1 = 1 TiB |
| done | output | 1 | One-cycle result strobe |
| vsid | output | 40 | Scrambled identifier (upper 12 bits zero in 1 TiB mode) |
| vsid_valid | output | 1 | Identifier is nonzero |

## Verification
The reduction cycle, which drives `done` and updates `vsid`, can coincide with a new `start` request. That request must be dropped. The next request is only accepted one cycle later.

The bench provokes this overlap by holding `start` high across several back-to-back requests and by pulsing it mid-computation with different operands. A behavioural countdown model predicts, on every clock, whether `done` is due and which operand set the held output must reflect. Any early acceptance shifts the done cycle and the value, and so shows up as a miscompare.

// File: rtl/vsid_pkg.sv
package vsid_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_MUL  = 2'd1,
        S_FOLD = 2'd2
    } vsid_state_e;
endpackage

// File: rtl/vsid_proto_build.sv
// Forms the proto identifier: context above the masked segment number.
module vsid_proto_build #(
    parameter int CTX_W  = 19,
    parameter int EA_W   = 64,
    parameter int SHIFT  = 28,
    parameter int ESID_W = 21,
    parameter int OUT_W  = 64
) (
    input  logic [CTX_W-1:0] ctx,
    input  logic [EA_W-1:0]  ea,
    output logic [OUT_W-1:0] proto
);
    localparam int P_W = CTX_W + ESID_W;

    logic [P_W-1:0] joined;

    always_comb begin
        joined = {ctx, ea[SHIFT +: ESID_W]};
        proto  = OUT_W'(joined);
    end
endmodule

// File: rtl/vsid_mul_step.sv
// One shift-add slice: adds proto * chunk, weighted by the slice index.
module vsid_mul_step #(
    parameter int PW    = 64,
    parameter int STEP  = 4,
    parameter int IDX_W = 3
) (
    input  logic [PW-1:0]    acc,
    input  logic [PW-1:0]    proto,
    input  logic [STEP-1:0]  chunk,
    input  logic [IDX_W-1:0] idx,
    output logic [PW-1:0]    acc_next
);
    logic [PW-1:0] term [STEP];

    genvar gi;
    generate
        for (gi = 0; gi < STEP; gi++) begin : g_term
            assign term[gi] = chunk[gi] ? (proto << gi) : '0;
        end
    endgenerate

    logic [PW-1:0] slice_sum;

    always_comb begin
        slice_sum = '0;
        for (int i = 0; i < STEP; i++) begin
            slice_sum = slice_sum + term[i];
        end
        acc_next = acc + (slice_sum << (32'(idx) * STEP));
    end
endmodule

// File: rtl/vsid_fold.sv
// Reduction modulo 2^N-1 by folding the high part onto the low part,
// followed by an end-around carry correction.
module vsid_fold #(
    parameter int PW = 64,
    parameter int N  = 40
) (
    input  logic [PW-1:0] prod,
    output logic [N-1:0]  res
);
    localparam logic [PW-1:0] MASK = (PW'(1) << N) - PW'(1);

    logic [PW-1:0] x;
    logic [PW-1:0] y;

    always_comb begin
        x   = (prod >> N) + (prod & MASK);
        y   = x + ((x + PW'(1)) >> N);
        res = y[N-1:0];
    end
endmodule

// File: rtl/vsid_scrambler.sv
module vsid_scrambler
    import vsid_pkg::*;
#(
    parameter int VA_BITS    = 68,
    parameter int CTX_W      = 19,
    parameter int EA_W       = 64,
    parameter int RANGE_BITS = 52,
    parameter int SHIFT_S    = 28,
    parameter int SHIFT_L    = 40,
    parameter int MULT_W     = 24,
    parameter int MULT       = 12538073,
    parameter int MUL_STEP   = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [CTX_W-1:0]           ctx,
    input  logic [EA_W-1:0]            ea,
    input  logic                       seg_1t,
    output logic                       done,
    output logic [VA_BITS-SHIFT_S-1:0] vsid,
    output logic                       vsid_valid
);
    localparam int N_S        = VA_BITS - SHIFT_S;
    localparam int N_L        = VA_BITS - SHIFT_L;
    localparam int ESID_S     = N_S - CTX_W;
    localparam int ESID_L     = N_L - CTX_W;
    localparam int VSID_W     = N_S;
    localparam int PW         = 64;
    localparam int MUL_CYCLES = MULT_W / MUL_STEP;
    localparam int CNT_W      = $clog2(MUL_CYCLES + 1);
    localparam logic [PW-1:0] MULT_V = PW'(MULT);
    localparam logic [PW-1:0] MOD_S  = (PW'(1) << N_S) - PW'(1);
    localparam logic [PW-1:0] MOD_L  = (PW'(1) << N_L) - PW'(1);

    vsid_state_e state, state_n;
    logic [CNT_W-1:0] cnt;
    logic [PW-1:0]    proto_q, acc_q, acc_next;
    logic             seg_q, bad_q;

    // Proto identifiers for both segment sizes
    logic [PW-1:0] proto_s, proto_l;

    vsid_proto_build #(
        .CTX_W(CTX_W), .EA_W(EA_W), .SHIFT(SHIFT_S),
        .ESID_W(ESID_S), .OUT_W(PW)
    ) u_proto_s (
        .ctx(ctx), .ea(ea), .proto(proto_s)
    );

    vsid_proto_build #(
        .CTX_W(CTX_W), .EA_W(EA_W), .SHIFT(SHIFT_L),
        .ESID_W(ESID_L), .OUT_W(PW)
    ) u_proto_l (
        .ctx(ctx), .ea(ea), .proto(proto_l)
    );

    // Multiplier slice
    logic [MUL_STEP-1:0] chunk;
    assign chunk = MUL_STEP'(MULT_V >> (32'(cnt) * MUL_STEP));

    vsid_mul_step #(
        .PW(PW), .STEP(MUL_STEP), .IDX_W(CNT_W)
    ) u_mul (
        .acc(acc_q), .proto(proto_q), .chunk(chunk),
        .idx(cnt), .acc_next(acc_next)
    );

    // Reductions for both moduli
    logic [N_S-1:0] red_s;
    logic [N_L-1:0] red_l;

    vsid_fold #(.PW(PW), .N(N_S)) u_fold_s (.prod(acc_q), .res(red_s));
    vsid_fold #(.PW(PW), .N(N_L)) u_fold_l (.prod(acc_q), .res(red_l));

    logic [VSID_W-1:0] vsid_n;

    always_comb begin
        if (bad_q) begin
            vsid_n = '0;
        end else if (seg_q) begin
            vsid_n = VSID_W'(red_l);
        end else begin
            vsid_n = red_s;
        end
    end

    // Next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            S_IDLE:  if (start) state_n = S_MUL;
            S_MUL:   if (cnt == CNT_W'(MUL_CYCLES - 1)) state_n = S_FOLD;
            S_FOLD:  state_n = S_IDLE;
            default: state_n = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            proto_q <= '0;
            acc_q   <= '0;
            seg_q   <= 1'b0;
            bad_q   <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        proto_q <= seg_1t ? proto_l : proto_s;
                        seg_q   <= seg_1t;
                        bad_q   <= |ea[EA_W-1:RANGE_BITS];
                        acc_q   <= '0;
                        cnt     <= '0;
                    end
                end
                S_MUL: begin
                    acc_q <= acc_next;
                    cnt   <= cnt + CNT_W'(1);
                end
                S_FOLD:  cnt <= '0;
                default: cnt <= '0;
            endcase
        end
    end

    // Output process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done       <= 1'b0;
            vsid       <= '0;
            vsid_valid <= 1'b0;
        end else begin
            done <= (state == S_FOLD);
            if (state == S_FOLD) begin
                vsid       <= vsid_n;
                vsid_valid <= (vsid_n != '0);
            end
        end
    end

    // R6
    fold_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FOLD) |=> done);

    // R6
    mul_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_MUL) |-> (cnt < CNT_W'(MUL_CYCLES)));

    // R7
    hold_between_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(vsid) && $stable(vsid_valid)));

    // R5
    valid_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vsid_valid == (vsid != '0));

    // R3
    below_modulus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (seg_q ? (PW'(vsid) < MOD_L) : (PW'(vsid) < MOD_S)));

    // R4
    range_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && bad_q) |-> (vsid == '0));
endmodule

// File: tb/vsid_scrambler_bench.sv
module vsid_scrambler_bench;
    localparam int LAT = 24 / 4 + 1;  // R6: 6 multiply cycles + 1 fold

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [18:0] ctx = '0;
    logic [63:0] ea = '0;
    logic        seg_1t = 1'b0;
    logic        done;
    logic [39:0] vsid;
    logic        vsid_valid;

    int vectors = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;  // 125 MHz

    vsid_scrambler u_vsid_scrambler (
        .clk(clk), .rst_n(rst_n), .start(start), .ctx(ctx), .ea(ea),
        .seg_1t(seg_1t), .done(done), .vsid(vsid), .vsid_valid(vsid_valid)
    );

    function automatic void ref_calc(input logic [18:0] c, input logic [63:0] e,
                                     input logic s, output logic [63:0] pr,
                                     output logic [39:0] v);
        int n;
        int sh;
        int ew;
        logic [127:0] md;
        logic [127:0] prod;
        n  = s ? 28 : 40;
        sh = s ? 40 : 28;
        ew = n - 19;
        pr = ({45'b0, c} << ew) | ((e >> sh) & ((64'd1 << ew) - 64'd1));
        md = (128'd1 << n) - 128'd1;
        prod = {64'b0, pr} * 128'd12538073;
        v = 40'(prod % md);
        if (e[63:52] != 12'd0) v = '0;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
        vectors++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    // Behavioural countdown model, compared every clock
    int          rem = 0;
    logic [39:0] pend_v = '0;
    logic [63:0] pend_p = '0;
    logic        pend_s = 1'b0;
    logic [39:0] held_v = '0;
    logic        exp_done;

    always @(negedge clk) begin
        if (rst_n) begin
            cycles++;
            exp_done = 1'b0;
            if (rem > 0) begin
                rem--;
                if (rem == 0) begin
                    exp_done = 1'b1;
                    held_v = pend_v;
                end
            end else if (start) begin
                ref_calc(ctx, ea, seg_1t, pend_p, pend_v);
                pend_s = seg_1t;
                rem = LAT;
            end
            // R6 R7: done timing, start ignored while busy
            check("R6/R7 done", {63'b0, done}, {63'b0, exp_done});
            // R1 R2 R4 R7: value and hold
            check("R2 vsid", {24'b0, vsid}, {24'b0, held_v});
            // R5
            check("R5 valid", {63'b0, vsid_valid}, {63'b0, held_v != 40'd0});
            if (exp_done && held_v != 40'd0) begin : inv_blk
                logic [127:0] md;
                logic [127:0] inv;
                md  = pend_s ? ((128'd1 << 28) - 1) : ((128'd1 << 40) - 1);
                inv = pend_s ? 128'd209034062 : 128'd665548017062;
                // R9: inverse recovers proto
                check("R9 inverse", 64'(({88'b0, vsid} * inv) % md), pend_p);
                // R3
                check("R3 below mod", {63'b0, {88'b0, vsid} < md}, 64'd1);
            end
            if (cycles > 150000) begin
                errors++;
                $display("FAIL watchdog: actual %0d expected <150000", cycles);
                $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
                $finish;
            end
        end
    end

    task automatic issue(input logic [18:0] c, input logic [63:0] e, input logic s);
        @(negedge clk);
        #2;
        ctx = c;
        ea = e;
        seg_1t = s;
        start = 1'b1;
        @(negedge clk);
        #2;
        start = 1'b0;
        repeat (LAT + 1) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8 done", {63'b0, done}, 64'd0);
        check("R8 vsid", {24'b0, vsid}, 64'd0);
        check("R8 valid", {63'b0, vsid_valid}, 64'd0);
        #2;
        rst_n = 1'b1;

        issue(19'd1, 64'h0000_0000_3000_0000, 1'b0);   // R1 R2 256M
        issue(19'd5, 64'h0000_0300_0000_0000, 1'b1);   // R1 R2 1T
        issue(19'd0, 64'h0, 1'b0);                     // R5 proto 0
        issue(19'h7FFFF, 64'h0001_FFFF_F000_0000, 1'b0); // R3 proto = mod (256M)
        issue(19'h7FFFF, 64'h0001_FF00_0000_0000, 1'b1); // R3 proto = mod (1T)
        issue(19'd9, 64'h0010_0000_0000_0000, 1'b0);   // R4 out of range
        issue(19'd9, 64'h8000_0000_1000_0000, 1'b1);   // R4 out of range
        issue(19'd3, 64'h000E_0000_1234_5678, 1'b0);   // R1 high bits masked

        // R7: start mid-computation with different operands
        @(negedge clk);
        #2;
        ctx = 19'd77; ea = 64'h0000_0000_5000_0000; seg_1t = 1'b0; start = 1'b1;
        @(negedge clk);
        #2;
        start = 1'b0;
        repeat (3) @(negedge clk);
        #2;
        ctx = 19'd78; ea = 64'h0000_0100_0000_0000; seg_1t = 1'b1; start = 1'b1;
        @(negedge clk);
        #2;
        start = 1'b0;
        repeat (LAT + 2) @(negedge clk);

        // R7: start held high, overlaps the fold cycle
        #2;
        ctx = 19'd123; ea = 64'h0000_0000_7000_0000; seg_1t = 1'b0; start = 1'b1;
        repeat (4 * (LAT + 1)) @(negedge clk);
        #2;
        start = 1'b0;
        repeat (LAT + 2) @(negedge clk);

        // R2 R9: mixed patterns
        for (int i = 0; i < 300; i++) begin
            logic [63:0] e;
            e = {$urandom, $urandom};
            if (i % 8 != 0) e[63:49] = '0;
            issue(19'($urandom), e, 1'($urandom));
        end

        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule